// File: doc/BRIEF.md
# Gate Driver Protection Control

This block is the clocked decision logic that sits between the command pins of an isolated power-transistor gate driver and its output stage. Two complementary command inputs select the gate state. Each command input passes through a two-stage synchronizer and a glitch filter, and the gate is turned on only when the input-side and output-side supplies both report good. A ready flag reports the state of both supplies. When the gate is off, a discharge enable empties the desaturation sense capacitor.

While the gate is on, a comparator bit reports that the sensed collector voltage is above the desaturation threshold. That bit is ignored for a blanking interval after every turn-on. After the blanking interval it must stay high for a set number of cycles before it counts as a fault. An accepted fault turns the gate off in the same cycle and drives an active-low fault flag. The fault stays latched whatever the commands do. Only a filtered low pulse on the fault-reset input that lasts long enough clears it. All times are parameters counted in clock cycles.

Top module: `gate_prot_ctrl`

## Requirements
- R1: The gate output rises only when the filtered non-inverting command is 1, the filtered inverting command is 0, ready is 1 and no fault is latched. All other command pairs leave the gate off.
- R2: A level change on either command input that lasts fewer than FILT_CYC (default 3) clock cycles has no effect on the gate. A change held for FILT_CYC cycles or longer is accepted.
- R3: The ready output is 1 only when both supply-good inputs are 1. The cycle after ready is 0, the gate output is 0.
- R4: The discharge enable is 1 exactly when the gate output is 0.
- R5: For BLANK_CYC (default 50) cycles after each rising edge of the gate output, the desaturation input has no effect. A latched fault can never appear fewer than BLANK_CYC+DESAT_CYC cycles after the gate rose.
- R6: After blanking, the desaturation input is accepted as a fault only once it has been sampled high for DESAT_CYC (default 41) consecutive cycles while the gate is on. A shorter high run is ignored.
- R7: When a fault is accepted, the gate output goes to 0 in the same cycle and the fault output (active low) goes to 0. Both stay there whatever the command inputs do until the fault is cleared.
- R8: The fault-reset input is active low and filtered like the commands. It clears the latched fault only after it has been low for RSTMIN_CYC (default 100) consecutive cycles. Shorter low pulses leave the fault set.
- R9: A clear applied while the desaturation input is still high releases the latch. If the command still asks for the gate on, the gate turns back on in the cycle after the clear. The next fault appears exactly BLANK_CYC+DESAT_CYC+1 cycles after the fault output went high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| sysRstN | input | 1 | Asynchronous active-low reset of all state |
| cmdPos | input | 1 | Non-inverting gate command (asynchronous) |
| cmdNeg | input | 1 | Inverting gate command (asynchronous) |
| faultRstN | input | 1 | Active-low fault-clear request (asynchronous) |
| supplyInOk | input | 1 | Input-side supply good (asynchronous) |
| supplyOutOk | input | 1 | Output-side supply good (asynchronous) |
| desatHi | input | 1 | Desaturation comparator output (asynchronous) |
| gateOn | output | 1 | Gate-on command to the output stage |
| dischargeEn | output | 1 | Sense-capacitor discharge enable |
| faultN | output | 1 | Latched fault flag, active low |
| ready | output | 1 | Both supplies good |

## Verification
The clear-width property counts low cycles on the raw fault-reset pin. It therefore assumes that every reset pulse is one clean low run, with no brief high glitch splitting it, which the filter would hide from the design. The bench drives every reset pulse as a single uninterrupted level. The bench changes all inputs one clock after the previous change, at the falling edge, so the synchronizer sees each change on exactly one rising edge. Supplies are raised before the first command, so the ready-gating property never depends on values from before reset.

// File: rtl/gate_prot_pkg.sv
`timescale 1ns/1ps
package gate_prot_pkg;
  // Conditioned inputs and event strobes from datapath to control
  typedef struct packed {
    logic cmdOn;
    logic supplyOk;
    logic faultHit;
    logic faultClear;
  } dpFlags_t;

  // State fed back from control to datapath
  typedef struct packed {
    logic gateOn;
  } ctlState_t;
endpackage

// File: rtl/gate_prot_syncfilt.sv
`timescale 1ns/1ps
module gate_prot_syncfilt #(
  parameter int unsigned FILT_CYC = 3,
  parameter logic        INIT     = 1'b0
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic rawIn,
  output logic filtOut
);
  logic [1:0] syncQ;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) syncQ <= {2{INIT}};
    else          syncQ <= {syncQ[0], rawIn};
  end

  generate
    if (FILT_CYC == 0) begin : g_bypass
      assign filtOut = syncQ[1];
    end else begin : g_filt
      localparam int CW = $clog2(FILT_CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
      logic [CW-1:0] runCnt;
      logic stateQ;
      // a new level must persist FILT_CYC sampled cycles before it is taken
      always_ff @(posedge clk or negedge sysRstN) begin
        if (!sysRstN) begin
          runCnt <= '0;
          stateQ <= INIT;
        end else if (syncQ[1] == stateQ) begin
          runCnt <= '0;
        end else if (runCnt == LAST) begin
          stateQ <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
      assign filtOut = stateQ;
    end
  endgenerate
endmodule

// File: rtl/gate_prot_datapath.sv
`timescale 1ns/1ps
module gate_prot_datapath
  import gate_prot_pkg::*;
#(
  parameter int unsigned FILT_CYC   = 3,
  parameter int unsigned BLANK_CYC  = 50,
  parameter int unsigned DESAT_CYC  = 41,
  parameter int unsigned RSTMIN_CYC = 100
) (
  input  logic      clk,
  input  logic      sysRstN,
  input  logic      cmdPos,
  input  logic      cmdNeg,
  input  logic      faultRstN,
  input  logic      supplyInOk,
  input  logic      supplyOutOk,
  input  logic      desatHi,
  input  ctlState_t ctl,
  output dpFlags_t  flags
);
  localparam int NIN = 6;
  // bit order: cmdPos, cmdNeg, faultRstN, supplyIn, supplyOut, desat
  localparam logic [NIN-1:0] INIT_V = 6'b000110;
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int DW = $clog2(DESAT_CYC + 1);
  localparam int RW = $clog2(RSTMIN_CYC + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
  localparam logic [DW-1:0] DESAT_LAST = DW'(DESAT_CYC - 1);
  localparam logic [RW-1:0] RST_END  = RW'(RSTMIN_CYC);
  localparam logic [RW-1:0] RST_LAST = RW'(RSTMIN_CYC - 1);

  logic [NIN-1:0] rawVec;
  logic [NIN-1:0] cleanVec;

  assign rawVec = {desatHi, supplyOutOk, supplyInOk, faultRstN, cmdNeg, cmdPos};

  // command and reset pins get the glitch filter, the rest only synchronize
  for (genvar i = 0; i < NIN; i++) begin : g_in
    gate_prot_syncfilt #(
      .FILT_CYC((i < 3) ? FILT_CYC : 0),
      .INIT    (INIT_V[i])
    ) u_in (
      .clk    (clk),
      .sysRstN(sysRstN),
      .rawIn  (rawVec[i]),
      .filtOut(cleanVec[i])
    );
  end

  logic cmdPosF, cmdNegF, rstF, desatS;
  assign cmdPosF = cleanVec[0];
  assign cmdNegF = cleanVec[1];
  assign rstF    = cleanVec[2];
  assign desatS  = cleanVec[5];

  // leading-edge blanking
  logic [BW-1:0] blankCnt;
  logic blankDone;
  assign blankDone = (blankCnt == BLANK_END);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)        blankCnt <= '0;
    else if (!ctl.gateOn) blankCnt <= '0;
    else if (!blankDone)  blankCnt <= blankCnt + 1'b1;
  end

  // desaturation persistence filter
  logic [DW-1:0] desatCnt;
  logic desatArmed;
  assign desatArmed = ctl.gateOn & blankDone & desatS;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                 desatCnt <= '0;
    else if (!desatArmed)         desatCnt <= '0;
    else if (desatCnt != DESAT_LAST) desatCnt <= desatCnt + 1'b1;
  end

  // fault-clear pulse width
  logic [RW-1:0] rstCnt;
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)          rstCnt <= '0;
    else if (rstF)         rstCnt <= '0;
    else if (rstCnt != RST_END) rstCnt <= rstCnt + 1'b1;
  end

  assign flags.cmdOn      = cmdPosF & ~cmdNegF;
  assign flags.supplyOk   = cleanVec[3] & cleanVec[4];
  assign flags.faultHit   = desatArmed & (desatCnt == DESAT_LAST);
  assign flags.faultClear = ~rstF & (rstCnt == RST_LAST);
endmodule

// File: rtl/gate_prot_control.sv
`timescale 1ns/1ps
module gate_prot_control
  import gate_prot_pkg::*;
(
  input  logic      clk,
  input  logic      sysRstN,
  input  dpFlags_t  flags,
  output ctlState_t ctl,
  output logic      gateOn,
  output logic      dischargeEn,
  output logic      faultN,
  output logic      ready
);
  logic faultQ;
  logic gateQ;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      faultQ <= 1'b0;
      gateQ  <= 1'b0;
    end else begin
      if (flags.faultHit)        faultQ <= 1'b1;
      else if (flags.faultClear) faultQ <= 1'b0;
      gateQ <= flags.cmdOn & flags.supplyOk & ~faultQ & ~flags.faultHit;
    end
  end

  assign ctl.gateOn  = gateQ;
  assign gateOn      = gateQ;
  assign dischargeEn = ~gateQ;
  assign faultN      = ~faultQ;
  assign ready       = flags.supplyOk;
endmodule

// File: rtl/gate_prot_ctrl.sv
`timescale 1ns/1ps
module gate_prot_ctrl
  import gate_prot_pkg::*;
#(
  parameter int unsigned FILT_CYC   = 3,
  parameter int unsigned BLANK_CYC  = 50,
  parameter int unsigned DESAT_CYC  = 41,
  parameter int unsigned RSTMIN_CYC = 100
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic cmdPos,
  input  logic cmdNeg,
  input  logic faultRstN,
  input  logic supplyInOk,
  input  logic supplyOutOk,
  input  logic desatHi,
  output logic gateOn,
  output logic dischargeEn,
  output logic faultN,
  output logic ready
);
  dpFlags_t  flags;
  ctlState_t ctl;

  gate_prot_datapath #(
    .FILT_CYC  (FILT_CYC),
    .BLANK_CYC (BLANK_CYC),
    .DESAT_CYC (DESAT_CYC),
    .RSTMIN_CYC(RSTMIN_CYC)
  ) u_dp (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .cmdPos     (cmdPos),
    .cmdNeg     (cmdNeg),
    .faultRstN  (faultRstN),
    .supplyInOk (supplyInOk),
    .supplyOutOk(supplyOutOk),
    .desatHi    (desatHi),
    .ctl        (ctl),
    .flags      (flags)
  );

  gate_prot_control u_ctl (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .flags      (flags),
    .ctl        (ctl),
    .gateOn     (gateOn),
    .dischargeEn(dischargeEn),
    .faultN     (faultN),
    .ready      (ready)
  );
endmodule

// File: rtl/gate_prot_checker.sv
`timescale 1ns/1ps
module gate_prot_checker #(
  parameter int unsigned BLANK_CYC  = 50,
  parameter int unsigned DESAT_CYC  = 41,
  parameter int unsigned RSTMIN_CYC = 100
) (
  input logic clk,
  input logic sysRstN,
  input logic faultRstN,
  input logic gateOn,
  input logic faultN,
  input logic ready
);
  localparam int unsigned CAP = BLANK_CYC + DESAT_CYC;
  localparam int OW = $clog2(CAP + 1);
  localparam int RW = $clog2(RSTMIN_CYC + 1);
  localparam logic [OW-1:0] ON_CAP   = OW'(CAP);
  localparam logic [RW-1:0] RUN_CAP  = RW'(RSTMIN_CYC);
  localparam logic [RW-1:0] RUN_LAST = RW'(RSTMIN_CYC - 1);

  logic [OW-1:0] onCnt;
  logic [RW-1:0] lowRun;
  logic longSeen;
  logic faultNd;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      onCnt    <= '0;
      lowRun   <= '0;
      longSeen <= 1'b0;
      faultNd  <= 1'b1;
    end else begin
      faultNd <= faultN;
      if (!gateOn)             onCnt <= '0;
      else if (onCnt != ON_CAP) onCnt <= onCnt + 1'b1;
      if (faultRstN)              lowRun <= '0;
      else if (lowRun != RUN_CAP) lowRun <= lowRun + 1'b1;
      if (faultNd && !faultN)                  longSeen <= 1'b0;
      else if (!faultRstN && lowRun == RUN_LAST) longSeen <= 1'b1;
    end
  end

  AST_GATE_RISE_CLEAN: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(gateOn) |-> (faultN && ready)); // R1
  AST_OFF_WITHOUT_READY: assert property (@(posedge clk) disable iff (!sysRstN)
    !ready |=> !gateOn); // R3
  AST_NO_EARLY_FAULT: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(faultN) |-> (onCnt == ON_CAP)); // R5
  AST_FAULT_FROM_ON: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(faultN) |-> $past(gateOn)); // R6
  AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!sysRstN)
    !faultN |-> !gateOn); // R7
  AST_CLEAR_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(faultN) |-> longSeen); // R8
endmodule

bind gate_prot_ctrl gate_prot_checker #(
  .BLANK_CYC (BLANK_CYC),
  .DESAT_CYC (DESAT_CYC),
  .RSTMIN_CYC(RSTMIN_CYC)
) u_chk (
  .clk      (clk),
  .sysRstN  (sysRstN),
  .faultRstN(faultRstN),
  .gateOn   (gateOn),
  .faultN   (faultN),
  .ready    (ready)
);

// File: tb/gate_prot_ctrl_test.sv
`timescale 1ns/1ps
module gate_prot_ctrl_test;
  localparam int FILT  = 3;
  localparam int BLANK = 50;
  localparam int DSAT  = 41;
  localparam int RMIN  = 100;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic cmdPos = 1'b0, cmdNeg = 1'b1, faultRstN = 1'b1;
  logic supplyInOk = 1'b0, supplyOutOk = 1'b0, desatHi = 1'b0;
  logic gateOn, dischargeEn, faultN, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gate_prot_ctrl #(
    .FILT_CYC(FILT), .BLANK_CYC(BLANK), .DESAT_CYC(DSAT), .RSTMIN_CYC(RMIN)
  ) uut (
    .clk(clk), .sysRstN(sysRstN), .cmdPos(cmdPos), .cmdNeg(cmdNeg),
    .faultRstN(faultRstN), .supplyInOk(supplyInOk), .supplyOutOk(supplyOutOk),
    .desatHi(desatHi), .gateOn(gateOn), .dischargeEn(dischargeEn),
    .faultN(faultN), .ready(ready)
  );

  // pos, neg, supplyIn, supplyOut, expected gate, expected ready
  localparam logic [5:0] VEC [8] = '{
    6'b10_11_11, 6'b00_11_01, 6'b11_11_01, 6'b01_11_01,
    6'b10_01_00, 6'b10_10_00, 6'b10_11_11, 6'b10_00_00
  };

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // watch outputs for n cycles, count cycles with gate on and fault low
  task automatic watch(input int n, output int onCyc, output int faultCyc);
    onCyc = 0;
    faultCyc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gateOn) onCyc++;
      if (!faultN) faultCyc++;
    end
  endtask

  task automatic resetPulse(input int n);
    faultRstN = 1'b0;
    waitCyc(n);
    faultRstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int onC, fC, riseT, fallT;
    supplyInOk = 1'b1;
    supplyOutOk = 1'b1;
    waitCyc(4);
    // reset state
    check("R1 reset gate", gateOn, 1'b0);
    check("R4 reset discharge", dischargeEn, 1'b1);
    check("R7 reset faultN", faultN, 1'b1);
    check("R3 reset ready", ready, 1'b0);
    sysRstN = 1'b1;
    waitCyc(10);

    // truth table of commands and supplies
    for (int i = 0; i < 8; i++) begin
      {cmdPos, cmdNeg, supplyInOk, supplyOutOk} = VEC[i][5:2];
      waitCyc(12);
      check("R1 gate vector", gateOn, VEC[i][1]);
      check("R3 ready vector", ready, VEC[i][0]);
      check("R4 discharge vector", dischargeEn, ~VEC[i][1]);
    end

    // R2: command glitch rejection
    supplyInOk = 1'b1; supplyOutOk = 1'b1;
    cmdPos = 1'b0; cmdNeg = 1'b0;
    waitCyc(12);
    cmdPos = 1'b1; waitCyc(FILT - 1); cmdPos = 1'b0;
    watch(15, onC, fC);
    checkInt("R2 short pos pulse", onC, 0);
    cmdPos = 1'b1; waitCyc(FILT); cmdPos = 1'b0;
    watch(15, onC, fC);
    checkInt("R2 full pos pulse", onC, FILT);
    cmdPos = 1'b1;
    waitCyc(12);
    cmdNeg = 1'b1; waitCyc(FILT - 1); cmdNeg = 1'b0;
    watch(15, onC, fC);
    checkInt("R2 short neg pulse", onC, 15);

    // R5: desaturation only inside blanking
    cmdPos = 1'b0;
    waitCyc(12);
    desatHi = 1'b1;
    cmdPos = 1'b1;
    waitCyc(6 + BLANK - 10);
    desatHi = 1'b0;
    watch(100, onC, fC);
    checkInt("R5 desat in blanking", fC, 0);
    check("R5 gate kept", gateOn, 1'b1);

    // R5/R7: persistent desaturation from turn-on
    cmdPos = 1'b0;
    waitCyc(12);
    desatHi = 1'b1;
    cmdPos = 1'b1;
    waitCyc(6 + BLANK + DSAT - 6);
    check("R5 no fault before window", faultN, 1'b1);
    waitCyc(10);
    check("R7 fault set", faultN, 1'b0);
    check("R7 gate forced off", gateOn, 1'b0);
    check("R4 discharge on fault", dischargeEn, 1'b1);
    desatHi = 1'b0;
    cmdPos = 1'b0; waitCyc(10); cmdPos = 1'b1; cmdNeg = 1'b0;
    watch(20, onC, fC);
    checkInt("R7 latched gate", onC, 0);
    checkInt("R7 latched fault", fC, 20);

    // R8: reset width
    resetPulse(RMIN - 5);
    waitCyc(20);
    check("R8 short reset", faultN, 1'b0);
    resetPulse(FILT - 1);
    waitCyc(20);
    check("R8 glitch reset", faultN, 1'b0);
    resetPulse(RMIN + 5);
    waitCyc(20);
    check("R8 long reset", faultN, 1'b1);
    check("R1 gate after clear", gateOn, 1'b1);

    // R6: desaturation persistence after blanking
    desatHi = 1'b1; waitCyc(DSAT - 4); desatHi = 1'b0;
    watch(20, onC, fC);
    checkInt("R6 short desat", fC, 0);
    desatHi = 1'b1; waitCyc(DSAT + 8);
    check("R6 long desat", faultN, 1'b0);

    // R9: clear with desat still present, fault returns after blanking
    riseT = -1;
    fallT = -1;
    faultRstN = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i == RMIN + 5) faultRstN = 1'b1;
      if (riseT < 0 && faultN) riseT = i;
      else if (riseT >= 0 && fallT < 0 && !faultN) fallT = i;
    end
    check("R8 clear with desat", riseT >= 0, 1'b1);
    checkInt("R9 refault spacing", fallT - riseT, BLANK + DSAT + 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule